// File: doc/BRIEF.md
# Bank-Interleaved Register File

This block stores 128 registers of 64 bits each and spreads them over eight banks. Each bank is a flip-flop array with one read port and one write port. The three least-significant bits of the 7-bit register number pick the bank, and the remaining four bits pick the row inside that bank. Neighbouring register numbers therefore land in different banks. Several functional units can then reach the file in the same cycle without a true multi-ported array.

There are four read request ports and two write request ports, one per requesting unit. In every cycle the block works out which requests share a bank. Each bank accepts the lowest-numbered requester and holds the others off with `ready` low. A held-off port keeps its request up and retries. Read data comes back one cycle after the grant. The block also drives per-bank read and write enables, which are high only while that bank is doing work, so that idle banks can be clock-gated.

Top module: `rf_banked_regfile`

## Requirements
- R1: A value written to register n (0 to 127) is returned, all 64 bits, by any later granted read of register n, provided no write to n falls in between.
- R2: Register number bits [2:0] select the bank and bits [6:3] select the row. For example, a lone read of register 77 enables bank 5 only.
- R3: Requests that target different banks are all granted in the same cycle. This holds for four reads to four distinct banks. It also holds for a read and a write to the same bank, each of which gets that bank's single port of its own kind.
- R4: When several valid reads target one bank in a cycle, only the lowest-numbered of them sees `rd_ready` high. The others see it low. An invalid port never sees `rd_ready` high.
- R5: When both valid writes target one bank, only write port 0 is accepted, so a bank takes at most one write per cycle. The rejected write leaves the register file unchanged.
- R6: A read granted at a clock edge presents its data on `rd_data` and raises `rd_resp_valid` for that port in the cycle after that edge. `rd_resp_valid` is low for ports not granted at the previous edge.
- R7: When a read and a write to the same register are both granted in the same cycle, the read returns the value held before the write.
- R8: `bank_rd_en[b]` is high exactly when a read to bank b is granted in the current cycle, and `bank_wr_en[b]` is high exactly when a write to bank b is granted. Untouched banks have both enables low.
- R9: While `rst_n` is low and at the first edge after it, all `rd_resp_valid` bits are low, and with no requests all enables and readies are low.
- R10: Register 0 is an ordinary storage register. A nonzero value written to it reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_valid | input | 4 | Read request valid, one bit per read port |
| rd_regnum | input | 4x7 | Register number for each read port |
| rd_ready | output | 4 | Read request granted this cycle |
| rd_resp_valid | output | 4 | Read data valid, one cycle after grant |
| rd_data | output | 4x64 | Read data for each read port |
| wr_valid | input | 2 | Write request valid, one bit per write port |
| wr_regnum | input | 2x7 | Register number for each write port |
| wr_data | input | 2x64 | Write data for each write port |
| wr_ready | output | 2 | Write request accepted this cycle |
| bank_rd_en | output | 8 | Per-bank read activity enable |
| bank_wr_en | output | 8 | Per-bank write activity enable |

## Verification
Two functions can fall in the same cycle: read arbitration on a bank, and a write to a register that the winning read is fetching. The bench provokes this with directed cycles: all reads aimed at one bank while a write hits the same register, and a same-bank read and write to different rows. Seeded random traffic with a small bank space adds many more such collisions. A bench function computes the expected grants, enables and read values from a shadow copy of the registers. The shadow copy is updated only after each cycle's reads have been captured, so a same-cycle read must return the old contents.

// File: rtl/rf_pkg.sv
// Package rf_pkg
// Shared sizing constants for the bank-interleaved register file.
// Assumes a power-of-two register count and a power-of-two bank count.
package rf_pkg;
    parameter int RF_NUM_REGS  = 128;
    parameter int RF_DATA_W    = 64;
    parameter int RF_NUM_BANKS = 8;
    parameter int RF_NUM_RD    = 4;
    parameter int RF_NUM_WR    = 2;
endpackage

// File: rtl/rf_prio_arb.sv
// Module rf_prio_arb
// Fixed-priority arbiter: grants the lowest-indexed active request.
// Purely combinational; assumes the caller holds requests that lose.
module rf_prio_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // Pick the first set bit, scanning from index 0 upward.
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rf_bank.sv
// Module rf_bank
// One storage bank: flip-flop array with one write and one registered read.
// Assumes the array contents need no reset; only the read register is reset.
// A read and a write to the same row in one cycle return the old row value.
module rf_bank #(
    parameter int ROWS   = 16,
    parameter int DATA_W = 64,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [ROW_W-1:0]  raddr,
    input  logic              we,
    input  logic [ROW_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [ROWS];

    // Store the write data into the addressed row.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Capture the addressed row into the output register on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/rf_banked_regfile.sv
// Module rf_banked_regfile
// Register file interleaved over banks by the low register-number bits.
// Each bank is arbitrated separately for reads and for writes (lowest port
// wins). Losing ports see ready low and must keep their request. Read data
// is registered one cycle after the grant. Bank enables reflect grants only,
// so idle banks can be clock-gated.
module rf_banked_regfile
    import rf_pkg::*;
#(
    parameter int NUM_REGS  = RF_NUM_REGS,
    parameter int DATA_W    = RF_DATA_W,
    parameter int NUM_BANKS = RF_NUM_BANKS,
    parameter int NUM_RD    = RF_NUM_RD,
    parameter int NUM_WR    = RF_NUM_WR,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_RD-1:0]              rd_valid,
    input  logic [NUM_RD-1:0][REG_W-1:0]   rd_regnum,
    output logic [NUM_RD-1:0]              rd_ready,
    output logic [NUM_RD-1:0]              rd_resp_valid,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
    input  logic [NUM_WR-1:0]              wr_valid,
    input  logic [NUM_WR-1:0][REG_W-1:0]   wr_regnum,
    input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data,
    output logic [NUM_WR-1:0]              wr_ready,
    output logic [NUM_BANKS-1:0]           bank_rd_en,
    output logic [NUM_BANKS-1:0]           bank_wr_en
);
    localparam int ROW_W = REG_W - BANK_W;
    localparam int ROWS  = NUM_REGS / NUM_BANKS;

    logic [NUM_BANKS-1:0][NUM_RD-1:0] rd_req, rd_gnt;
    logic [NUM_BANKS-1:0][NUM_WR-1:0] wr_req, wr_gnt;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
    logic [NUM_RD-1:0][BANK_W-1:0]    rd_bank_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [ROW_W-1:0]  rrow, wrow;
        logic [DATA_W-1:0] wdat;

        // Flag the ports whose register number maps onto this bank.
        always_comb begin
            for (int p = 0; p < NUM_RD; p++)
                rd_req[b][p] = rd_valid[p] && (rd_regnum[p][BANK_W-1:0] == BANK_W'(b));
            for (int w = 0; w < NUM_WR; w++)
                wr_req[b][w] = wr_valid[w] && (wr_regnum[w][BANK_W-1:0] == BANK_W'(b));
        end

        rf_prio_arb #(.N(NUM_RD)) u_rd_arb (.req(rd_req[b]), .gnt(rd_gnt[b]));
        rf_prio_arb #(.N(NUM_WR)) u_wr_arb (.req(wr_req[b]), .gnt(wr_gnt[b]));

        // Steer the granted ports' row and data into the bank.
        always_comb begin
            rrow = '0;
            wrow = '0;
            wdat = '0;
            for (int p = 0; p < NUM_RD; p++)
                if (rd_gnt[b][p]) rrow = rd_regnum[p][REG_W-1:BANK_W];
            for (int w = 0; w < NUM_WR; w++)
                if (wr_gnt[b][w]) begin
                    wrow = wr_regnum[w][REG_W-1:BANK_W];
                    wdat = wr_data[w];
                end
        end

        assign bank_rd_en[b] = |rd_gnt[b];
        assign bank_wr_en[b] = |wr_gnt[b];

        rf_bank #(.ROWS(ROWS), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .re    (bank_rd_en[b]),
            .raddr (rrow),
            .we    (bank_wr_en[b]),
            .waddr (wrow),
            .wdata (wdat),
            .rdata (bank_rdata[b])
        );

        AST_RD_ONE_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(rd_ready & rd_req[b]) <= 1);    // R4
        AST_WR_ONE_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(wr_ready & wr_req[b]) <= 1);    // R5
        AST_IDLE_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            !(|rd_req[b]) |-> !bank_rd_en[b]);         // R8
        AST_IDLE_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            !(|wr_req[b]) |-> !bank_wr_en[b]);         // R8
        AST_BUSY_RD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
            (|rd_req[b]) |-> bank_rd_en[b]);           // R8
    end

    // Collect each port's grant across all banks.
    always_comb begin
        rd_ready = '0;
        wr_ready = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            rd_ready = rd_ready | rd_gnt[b];
            wr_ready = wr_ready | wr_gnt[b];
        end
    end

    // Remember which ports were granted and which bank serves each one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_resp_valid <= '0;
            rd_bank_q     <= '0;
        end else begin
            rd_resp_valid <= rd_valid & rd_ready;
            for (int p = 0; p < NUM_RD; p++)
                rd_bank_q[p] <= rd_regnum[p][BANK_W-1:0];
        end
    end

    // Route each bank's registered output back to its requesting port.
    always_comb begin
        for (int p = 0; p < NUM_RD; p++)
            rd_data[p] = bank_rdata[rd_bank_q[p]];
    end

    AST_PORT0_RD_NEVER_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid[0] |-> rd_ready[0]);                  // R4
    AST_PORT0_WR_NEVER_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid[0] |-> wr_ready[0]);                  // R5
    AST_NO_READY_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready & ~rd_valid) == '0);                 // R4
    AST_RESP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid[0] && rd_ready[0] |=> rd_resp_valid[0]); // R6
    AST_NO_RESP_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid[NUM_RD-1] |=> !rd_resp_valid[NUM_RD-1]); // R6
endmodule

// File: tb/rf_banked_regfile_tb.sv
module rf_banked_regfile_tb;
    localparam int NR = 4;
    localparam int NW = 2;
    localparam int NB = 8;
    localparam int RW = 7;
    localparam int DW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NR-1:0]         rd_valid;
    logic [NR-1:0][RW-1:0] rd_regnum;
    logic [NR-1:0]         rd_ready;
    logic [NR-1:0]         rd_resp_valid;
    logic [NR-1:0][DW-1:0] rd_data;
    logic [NW-1:0]         wr_valid;
    logic [NW-1:0][RW-1:0] wr_regnum;
    logic [NW-1:0][DW-1:0] wr_data;
    logic [NW-1:0]         wr_ready;
    logic [NB-1:0]         bank_rd_en;
    logic [NB-1:0]         bank_wr_en;

    rf_banked_regfile u_dut (.*);

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [128];

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected read grants: valid and no lower valid port in the same bank.
    function automatic logic [NR-1:0] exp_rd_rdy();
        logic [NR-1:0] r = '0;
        for (int p = 0; p < NR; p++) begin
            r[p] = rd_valid[p];
            for (int q = 0; q < p; q++)
                if (rd_valid[q] && rd_regnum[q][2:0] == rd_regnum[p][2:0]) r[p] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [NW-1:0] exp_wr_rdy();
        logic [NW-1:0] r = '0;
        for (int p = 0; p < NW; p++) begin
            r[p] = wr_valid[p];
            for (int q = 0; q < p; q++)
                if (wr_valid[q] && wr_regnum[q][2:0] == wr_regnum[p][2:0]) r[p] = 1'b0;
        end
        return r;
    endfunction

    task automatic idle();
        rd_valid = '0; rd_regnum = '0;
        wr_valid = '0; wr_regnum = '0; wr_data = '0;
    endtask

    // One cycle: check grants/enables, update the shadow copy, check responses.
    task automatic cycle(string dtag);
        logic [NR-1:0] er;
        logic [NW-1:0] ew;
        logic [NB-1:0] ren, wen;
        logic [DW-1:0] ed [NR];
        #1;
        er = exp_rd_rdy();
        ew = exp_wr_rdy();
        ren = '0; wen = '0;
        for (int p = 0; p < NR; p++) if (er[p]) ren[rd_regnum[p][2:0]] = 1'b1;
        for (int w = 0; w < NW; w++) if (ew[w]) wen[wr_regnum[w][2:0]] = 1'b1;
        chk("R4", DW'(rd_ready), DW'(er));
        chk("R5", DW'(wr_ready), DW'(ew));
        chk("R8", DW'(bank_rd_en), DW'(ren));
        chk("R8", DW'(bank_wr_en), DW'(wen));
        for (int p = 0; p < NR; p++) ed[p] = er[p] ? model[rd_regnum[p]] : '0;
        for (int w = 0; w < NW; w++) if (ew[w]) model[wr_regnum[w]] = wr_data[w];
        @(posedge clk); #2;
        chk("R6", DW'(rd_resp_valid), DW'(er));
        for (int p = 0; p < NR; p++) if (er[p]) chk(dtag, rd_data[p], ed[p]);
    endtask

    function automatic logic [DW-1:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        // R9: reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R9", DW'(rd_resp_valid), '0);
        chk("R9", DW'(bank_rd_en), '0);
        chk("R9", DW'(bank_wr_en), '0);
        chk("R9", DW'(rd_ready), '0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R9", DW'(rd_resp_valid), '0);

        // Fill every register; the two write ports hit neighbouring banks (R3).
        for (int i = 0; i < 64; i++) begin
            wr_valid = 2'b11;
            wr_regnum[0] = RW'(2 * i);
            wr_regnum[1] = RW'(2 * i + 1);
            wr_data[0] = rnd64();
            wr_data[1] = rnd64();
            cycle("R1");
        end
        idle();

        // R2: register 77 maps to bank 5 only.
        rd_valid = 4'b0001; rd_regnum[0] = 7'd77;
        #1 chk("R2", DW'(bank_rd_en), DW'(8'h20));
        cycle("R1");

        // R3: four reads to four distinct banks, plus a read and a write sharing a bank.
        rd_valid = 4'hF;
        rd_regnum[0] = 7'd8; rd_regnum[1] = 7'd17; rd_regnum[2] = 7'd42; rd_regnum[3] = 7'd127;
        wr_valid = 2'b01; wr_regnum[0] = 7'd16; wr_data[0] = rnd64();
        #1 chk("R3", DW'(rd_ready), DW'(4'hF));
        chk("R3", DW'(wr_ready), DW'(2'b01));
        cycle("R1");
        idle();

        // R4: all four reads aim at bank 3, and a write hits port 0's register (R7).
        rd_valid = 4'hF;
        rd_regnum[0] = 7'd3; rd_regnum[1] = 7'd11; rd_regnum[2] = 7'd19; rd_regnum[3] = 7'd27;
        wr_valid = 2'b01; wr_regnum[0] = 7'd3; wr_data[0] = rnd64();
        #1 chk("R4", DW'(rd_ready), DW'(4'b0001));
        cycle("R7");
        rd_valid = 4'b1110; wr_valid = '0;
        cycle("R1");
        idle();

        // R5: both writes to bank 6; only port 0 lands, port 1's register keeps its value.
        wr_valid = 2'b11; wr_regnum[0] = 7'd6; wr_regnum[1] = 7'd14;
        wr_data[0] = rnd64(); wr_data[1] = rnd64();
        #1 chk("R5", DW'(wr_ready), DW'(2'b01));
        cycle("R1");
        idle();
        rd_valid = 4'b0011; rd_regnum[0] = 7'd14; rd_regnum[1] = 7'd6;
        cycle("R5");
        idle();

        // R10: register 0 holds data.
        wr_valid = 2'b10; wr_regnum[1] = 7'd0; wr_data[1] = 64'hDEAD_BEEF_0123_4567;
        cycle("R10");
        idle();
        rd_valid = 4'b0100; rd_regnum[2] = 7'd0;
        cycle("R10");
        idle();

        // Random traffic in a narrow window so banks and registers collide often.
        for (int n = 0; n < 400; n++) begin
            for (int p = 0; p < NR; p++) begin
                rd_valid[p] = ($urandom % 4) != 0;
                rd_regnum[p] = RW'($urandom % 24);
            end
            for (int w = 0; w < NW; w++) begin
                wr_valid[w] = ($urandom % 2) != 0;
                wr_regnum[w] = RW'($urandom % 24);
                wr_data[w] = rnd64();
            end
            cycle("R7");
        end
        idle();
        cycle("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule